// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM and brings the memory from power-on to its operating mode. After a synchronous reset it keeps the clock-enable low for a stable-clock interval. The interval is given in microseconds and turned into a cycle count from a clock-frequency parameter. It then raises clock-enable while sending NOP. After that it drives a fixed series of commands: a precharge of all banks, an extended mode set that enables the DLL, a mode set that resets the DLL, a second precharge of all banks, a programmable number of auto-refresh commands, and a final mode set that clears the DLL reset bit.

Every gap between commands is a parameter counted in clock cycles, and NOP fills each gap. A separate window counts the DLL lock time from the DLL-reset mode set. The done flag goes high only when that window has run out and the final mode-set gap has passed. All outputs are registered. A synchronous reset at any point restarts the whole series.

Top module: `ddr_power_up_seq`

## Requirements
- R1: From the last clock edge that samples reset high, `cke` stays low and the command pins (cs_n, ras_n, cas_n, we_n) show NOP = 0111 for exactly CLK_MHZ*STABLE_US cycles, with `init_done` low.
- R2: `cke` rises with NOP on the command pins and then never falls until the next reset. The first non-NOP command follows CKE_SETUP_CYC cycles after `cke` rises.
- R3: The non-NOP commands come in this exact order: precharge-all, extended mode set, mode set with A8=1, precharge-all, NUM_REFRESH auto-refreshes, mode set with A8=0.
- R4: Encodings on (cs_n, ras_n, cas_n, we_n): precharge = 0010 with addr bit 10 = 1 and all other address bits 0 and ba = 0; auto-refresh = 0001 with addr = 0 and ba = 0; mode set = 0000. The mode register uses ba = 00 and addr = {A8, A6:A4 = MR_CL, A3 = 0, A2:A0 = MR_BL}. The extended mode register uses ba = 01 and addr = EMR_VAL.
- R5: Each mode or extended mode set is followed by exactly TMRD_CYC cycles before the next command.
- R6: Each precharge-all is followed by exactly TRP_CYC cycles before the next command.
- R7: Each auto-refresh is followed by exactly TRFC_CYC cycles before the next command.
- R8: `init_done` rises exactly max(DLL_LOCK_CYC cycles after the DLL-reset mode set, TMRD_CYC cycles after the final mode set) and stays high until reset.
- R9: Every cycle outside the listed commands carries NOP with ba = 0 and addr = 0, including all cycles after `init_done` is high. No non-NOP command is issued while `cke` is low.
- R10: A synchronous reset asserted at any time, including mid-series or after `init_done`, returns all outputs to the R1 state on the next edge. Release of the reset restarts the full series.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, also forwarded to the memory |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Memory clock-enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus carrying mode words and the A10 all-bank flag |
| init_done | output | 1 | High once the memory may take its first normal command |

## Verification
Every output is one register stage after the edge that decides it. The bench numbers cycles from the last edge that sees reset high. With that numbering, `cke` is due at cycle CLK_MHZ*STABLE_US, and each command is due at the previous command's cycle plus its minimum gap. `init_done` is due at the later of the lock-window end and the final mode-set gap end. The bench builds this timeline from the parameters alone and compares every output on every falling edge, half a cycle after the edge that set it. A second monitor measures the distance between observed commands and checks it against the gap of the command type that came before. Resets are applied mid-refresh and after completion, and the cycle numbering restarts with each one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_NOP = 4'b0111;
    localparam cmd_pins_t CMD_PRE = 4'b0010;
    localparam cmd_pins_t CMD_REF = 4'b0001;
    localparam cmd_pins_t CMD_MRS = 4'b0000;

    // bit position of the all-bank flag on precharge
    localparam int unsigned ALL_BANK_BIT = 10;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_PRE_A,
        ST_EMR,
        ST_MR_RST,
        ST_PRE_B,
        ST_REF,
        ST_MR_RUN,
        ST_SETTLE,
        ST_READY
    } init_step_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // mode word: A2:A0 burst length code, A3 sequential, A6:A4 latency code, A8 DLL reset
    function automatic logic [15:0] mode_word(input logic [2:0] bl, input logic [2:0] cl,
                                              input logic dll_rst);
        logic [15:0] w;
        w      = '0;
        w[2:0] = bl;
        w[6:4] = cl;
        w[8]   = dll_rst;
        return w;
    endfunction

endpackage

// File: rtl/dinit_gap_timer.sv
module dinit_gap_timer #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned RESET_LOAD = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RESET_LOAD);
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dinit_lock_window.sv
module dinit_lock_window #(
    parameter int unsigned LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic elapsed_o
);
    localparam int unsigned LW = $clog2(LOCK_CYC + 1);
    localparam logic [LW-1:0] LOAD = LW'(LOCK_CYC - 1);

    logic [LW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= LOAD;
            run_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign elapsed_o = run_q && (cnt_q == '0);

    // R8
    lock_count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_q == LOAD) && !elapsed_o || (LOCK_CYC == 1));

endmodule

// File: rtl/dinit_step_decode.sv
module dinit_step_decode
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned MR_BL         = 1,
    parameter int unsigned MR_CL         = 6,
    parameter int unsigned EMR_VAL       = 0,
    parameter int unsigned CKE_SETUP_CYC = 2,
    parameter int unsigned TRP_CYC       = 3,
    parameter int unsigned TMRD_CYC      = 2,
    parameter int unsigned TRFC_CYC      = 8
) (
    input  init_step_t        step_i,
    output cmd_pins_t         cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  gap_o
);
    localparam logic [15:0] MR_RST_FULL = mode_word(3'(MR_BL), 3'(MR_CL), 1'b1);
    localparam logic [15:0] MR_RUN_FULL = mode_word(3'(MR_BL), 3'(MR_CL), 1'b0);
    localparam logic [ADDR_W-1:0] MR_RST_WORD = MR_RST_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MR_RUN_WORD = MR_RUN_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] EMR_WORD    = ADDR_W'(EMR_VAL);
    localparam logic [ADDR_W-1:0] PRE_WORD    = ADDR_W'(1) << ALL_BANK_BIT;

    localparam logic [BA_W-1:0] BA_MODE = BA_W'(0);
    localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);

    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        gap_o  = '0;
        unique case (step_i)
            ST_STABLE: gap_o = CNT_W'(CKE_SETUP_CYC - 1);
            ST_PRE_A, ST_PRE_B: begin
                cmd_o  = CMD_PRE;
                addr_o = PRE_WORD;
                gap_o  = CNT_W'(TRP_CYC - 1);
            end
            ST_EMR: begin
                cmd_o  = CMD_MRS;
                ba_o   = BA_EXT;
                addr_o = EMR_WORD;
                gap_o  = CNT_W'(TMRD_CYC - 1);
            end
            ST_MR_RST: begin
                cmd_o  = CMD_MRS;
                ba_o   = BA_MODE;
                addr_o = MR_RST_WORD;
                gap_o  = CNT_W'(TMRD_CYC - 1);
            end
            ST_REF: begin
                cmd_o = CMD_REF;
                gap_o = CNT_W'(TRFC_CYC - 1);
            end
            ST_MR_RUN: begin
                cmd_o  = CMD_MRS;
                ba_o   = BA_MODE;
                addr_o = MR_RUN_WORD;
                gap_o  = CNT_W'(TMRD_CYC - 1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_power_up_seq.sv
module ddr_power_up_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned STABLE_US     = 200,
    parameter int unsigned CKE_SETUP_CYC = 2,
    parameter int unsigned TRP_CYC       = 3,
    parameter int unsigned TRFC_CYC      = 8,
    parameter int unsigned TMRD_CYC      = 2,
    parameter int unsigned DLL_LOCK_CYC  = 200,
    parameter int unsigned NUM_REFRESH   = 2,
    parameter int unsigned MR_BL         = 1,
    parameter int unsigned MR_CL         = 6,
    parameter int unsigned EMR_VAL       = 0,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int unsigned MAX_GAP = max_u(max_u(STABLE_CYC, CKE_SETUP_CYC),
                                            max_u(max_u(TRP_CYC, TRFC_CYC), TMRD_CYC));
    localparam int unsigned CNT_W = $clog2(MAX_GAP + 1);
    localparam int unsigned RC_W  = $clog2(NUM_REFRESH + 1);
    localparam logic [RC_W-1:0] REF_LAST = RC_W'(NUM_REFRESH - 1);

    init_step_t        step_q, step_d;
    logic [RC_W-1:0]   ref_cnt_q;
    logic              timer_zero, lock_elapsed, fire;
    cmd_pins_t         dec_cmd, cmd_q;
    logic [BA_W-1:0]   dec_ba, ba_q;
    logic [ADDR_W-1:0] dec_addr, addr_q;
    logic [CNT_W-1:0]  dec_gap;
    logic              cke_q, done_q;

    dinit_step_decode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .MR_BL(MR_BL), .MR_CL(MR_CL), .EMR_VAL(EMR_VAL),
        .CKE_SETUP_CYC(CKE_SETUP_CYC), .TRP_CYC(TRP_CYC),
        .TMRD_CYC(TMRD_CYC), .TRFC_CYC(TRFC_CYC)
    ) u_decode (
        .step_i(step_q), .cmd_o(dec_cmd), .ba_o(dec_ba),
        .addr_o(dec_addr), .gap_o(dec_gap)
    );

    dinit_gap_timer #(
        .CNT_W(CNT_W), .RESET_LOAD(STABLE_CYC - 1)
    ) u_timer (
        .clk(clk), .rst(rst), .load_i(fire),
        .load_val_i(dec_gap), .zero_o(timer_zero)
    );

    dinit_lock_window #(
        .LOCK_CYC(DLL_LOCK_CYC)
    ) u_lock (
        .clk(clk), .rst(rst),
        .start_i(fire && (step_q == ST_MR_RST)),
        .elapsed_o(lock_elapsed)
    );

    assign fire = timer_zero && (step_q != ST_READY) &&
                  ((step_q != ST_SETTLE) || lock_elapsed);

    always_comb begin
        step_d = step_q;
        if (fire) begin
            unique case (step_q)
                ST_STABLE: step_d = ST_PRE_A;
                ST_PRE_A:  step_d = ST_EMR;
                ST_EMR:    step_d = ST_MR_RST;
                ST_MR_RST: step_d = ST_PRE_B;
                ST_PRE_B:  step_d = ST_REF;
                ST_REF:    step_d = (ref_cnt_q == REF_LAST) ? ST_MR_RUN : ST_REF;
                ST_MR_RUN: step_d = ST_SETTLE;
                ST_SETTLE: step_d = ST_READY;
                default:   step_d = step_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= ST_STABLE;
            ref_cnt_q <= '0;
            cmd_q     <= CMD_NOP;
            ba_q      <= '0;
            addr_q    <= '0;
            cke_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            step_q <= step_d;
            if (fire && (step_q == ST_REF))
                ref_cnt_q <= ref_cnt_q + 1'b1;
            if (fire) begin
                cmd_q  <= dec_cmd;
                ba_q   <= dec_ba;
                addr_q <= dec_addr;
            end else begin
                cmd_q  <= CMD_NOP;
                ba_q   <= '0;
                addr_q <= '0;
            end
            if (fire && (step_q == ST_STABLE))
                cke_q <= 1'b1;
            if (fire && (step_q == ST_SETTLE))
                done_q <= 1'b1;
        end
    end

    assign cke       = cke_q;
    assign cs_n      = cmd_q.cs_n;
    assign ras_n     = cmd_q.ras_n;
    assign cas_n     = cmd_q.cas_n;
    assign we_n      = cmd_q.we_n;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign init_done = done_q;

    // R9
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NOP) |-> cke);

    // R2
    cke_holds_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done && (cmd_q == CMD_NOP));

    // R8
    done_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> lock_elapsed);

    // R5
    mode_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));

    // R6
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_PRE) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/tb_ddr_power_up_seq.sv
module tb_ddr_power_up_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ = 100, STABLE_US = 200, CKE_SETUP = 2, TRP = 3;
    localparam int TRFC = 10, TMRD = 2, LOCK = 200, NREF = 3;
    localparam int MR_BL = 1, MR_CL = 6, EMR_VAL = 0, ADDR_W = 13, BA_W = 2;
    localparam int STABLE = CLK_MHZ * STABLE_US;
    localparam int WATCHDOG = 120000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;

    ddr_power_up_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .CKE_SETUP_CYC(CKE_SETUP),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .DLL_LOCK_CYC(LOCK),
        .NUM_REFRESH(NREF), .MR_BL(MR_BL), .MR_CL(MR_CL), .EMR_VAL(EMR_VAL),
        .ADDR_W(ADDR_W), .BA_W(BA_W)
    ) dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int n = 0;
    bit mon_on = 1'b0;

    int ev_t[$];
    int ev_c[$];
    int ev_b[$];
    int ev_a[$];
    int done_t;
    int mrs_rst_t;
    int ref1_t;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, n, act, exp);
        end
    endtask

    task automatic push_ev(input int t, input int c, input int b, input int a);
        ev_t.push_back(t); ev_c.push_back(c); ev_b.push_back(b); ev_a.push_back(a);
    endtask

    // timeline from the requirements: each command at previous plus its gap
    task automatic build_model();
        int t;
        int mode_base;
        mode_base = (MR_CL << 4) | MR_BL;
        t = STABLE + CKE_SETUP;
        push_ev(t, 4'b0010, 0, 1 << 10);              t += TRP;
        push_ev(t, 4'b0000, 1, EMR_VAL);              t += TMRD;
        push_ev(t, 4'b0000, 0, mode_base | 32'h100);  mrs_rst_t = t; t += TMRD;
        push_ev(t, 4'b0010, 0, 1 << 10);              t += TRP;
        ref1_t = t;
        for (int k = 0; k < NREF; k++) begin
            push_ev(t, 4'b0001, 0, 0);
            t += TRFC;
        end
        push_ev(t, 4'b0000, 0, mode_base);            t += TMRD;
        done_t = (t > mrs_rst_t + LOCK) ? t : mrs_rst_t + LOCK;
    endtask

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            int hit;
            int ec, eb, ea;
            hit = -1;
            for (int i = 0; i < ev_t.size(); i++)
                if (ev_t[i] == n) hit = i;
            ec = (hit >= 0) ? ev_c[hit] : 4'b0111;
            eb = (hit >= 0) ? ev_b[hit] : 0;
            ea = (hit >= 0) ? ev_a[hit] : 0;
            check(cke == (n >= STABLE), (n < STABLE) ? "R1 cke low" : "R2 cke high",
                  int'(cke), int'(n >= STABLE));
            check({cs_n, ras_n, cas_n, we_n} == 4'(ec),
                  (hit >= 0) ? "R3 command order" : "R9 NOP fill",
                  int'({cs_n, ras_n, cas_n, we_n}), ec);
            check(int'(ba) == eb, (hit >= 0) ? "R4 bank field" : "R9 bank idle", int'(ba), eb);
            check(int'(addr) == ea, (hit >= 0) ? "R4 address field" : "R9 address idle",
                  int'(addr), ea);
            check(init_done == (n >= done_t), "R8 done timing", int'(init_done),
                  int'(n >= done_t));
        end
    end

    // gap monitor independent of the timeline
    bit have_prev = 1'b0;
    int prev_t = 0;
    int prev_c = 0;
    always @(negedge clk) begin
        if (rst) begin
            have_prev = 1'b0;
        end else if (mon_on && ({cs_n, ras_n, cas_n, we_n} != 4'b0111)) begin
            int c;
            c = int'({cs_n, ras_n, cas_n, we_n});
            if (!have_prev) begin
                check(n - STABLE >= CKE_SETUP, "R2 first command after cke", n - STABLE, CKE_SETUP);
            end else if (prev_c == 4'b0010) begin
                check(n - prev_t >= TRP, "R6 precharge gap", n - prev_t, TRP);
            end else if (prev_c == 4'b0001) begin
                check(n - prev_t >= TRFC, "R7 refresh gap", n - prev_t, TRFC);
            end else begin
                check(n - prev_t >= TMRD, "R5 mode set gap", n - prev_t, TMRD);
            end
            have_prev = 1'b1;
            prev_t = n;
            prev_c = c;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired: actual no completion expected done by cycle %0d", done_t);
        summary();
        $finish;
    end

    initial begin
        build_model();
        rst = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R3 R8: full run
        while (n < done_t + 20) @(negedge clk);
        // R10: reset in the middle of the refresh phase
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        while (n < ref1_t + 1) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (n < done_t + 20) @(negedge clk);
        // R10: reset after completion, then a short restart
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        summary();
        $finish;
    end

endmodule